// File: doc/BRIEF.md
# Registering Clock Driver Control Word Loader

This block walks through the full set of control words of a DDR4 registering clock driver and issues one write command per word over a valid/ready handshake. A single start pulse launches the sequence. The configuration is taken from two flat input vectors. One holds the sixteen 4-bit words and the other holds the eleven 8-bit words.

Each write names the word index, a width-class flag and the data. After the handshake the block stays silent for a settling gap that belongs to that word. The gap is a short register delay of 8 cycles, a long delay of 16 cycles, or a stabilisation wait of a number of microseconds. The stabilisation wait is turned into clock cycles from a clock-period parameter given in picoseconds. When the gap after the final 8-bit word has run out, the block raises done. Done stays high until the next start.

Top module: `rcw_loader`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `cmd_valid_o`, `done_o` and `busy_o` are low. A reset in the middle of a sequence abandons it.
- R2: The 4-bit words go out first, in the index order 0,1,2,3,4,5,6,8,9,...,15, with `cmd_wide_o`=0. Index 7 is never sent alone. The write at index 6 carries data {word7, word6}, with word7 in bits 7:4 and word6 in bits 3:0. Every other 4-bit write carries its word in bits 3:0, with bits 7:4 zero.
- R3: After the last 4-bit word, the 8-bit words go out at indices 1 through 11, in increasing order, with `cmd_wide_o`=1. The data is word k of the 8-bit vector, taken from bits (k-1)*8+7:(k-1)*8.
- R4: After a handshake on a write with the short gap, `cmd_valid_o` stays low for exactly SHORT_GAP cycles (default 8) before the next write is offered or done rises.
- R5: The long gap of LONG_GAP cycles (default 16) follows 4-bit words 3, 4 and 5 and 8-bit word 11.
- R6: The stabilisation gap follows 4-bit words 2 and 10 and 8-bit word 3. It lasts ceil(STAB_US*1e6 / CLK_PS) cycles, so it is never shorter than STAB_US microseconds.
- R7: While `cmd_ready_i` is low, an offered write stays valid with an unchanged index, width flag and data. The gap is counted from the cycle of the handshake.
- R8: `done_o` rises when the gap after 8-bit word 11 expires. It stays high, with `cmd_valid_o` low, until the next start. A start pulse during a sequence is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launches a sequence when idle |
| narrow_cfg_i | input | 16*NARROW_BITS | 4-bit word k at bits k*4 upward |
| wide_cfg_i | input | 11*WIDE_BITS | 8-bit word k (1..11) at bits (k-1)*8 upward |
| cmd_ready_i | input | 1 | Consumer accepts the offered write |
| cmd_valid_o | output | 1 | Write command offered |
| cmd_wide_o | output | 1 | 1 for an 8-bit word, 0 for a 4-bit word |
| cmd_index_o | output | 4 | Control word index |
| cmd_data_o | output | WIDE_BITS | Write data |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | Last gap expired |

## Verification
The bench builds the block with CLK_PS=15000 and STAB_US=5. The period does not divide 5 microseconds evenly, so the rounding up to 334 cycles is exposed. It also keeps each stabilisation wait short enough that two complete sequences fit easily in one run. SHORT_GAP and LONG_GAP keep their defaults, so the measured silent periods of 8 and 16 cycles can be told apart from each other and from the stabilisation wait.

// File: rtl/rcw_pkg.sv
package rcw_pkg;
  localparam int NARROW_CNT   = 16;
  localparam int WIDE_CNT     = 11;
  localparam int NARROW_STEPS = 15;
  localparam int TOTAL_STEPS  = NARROW_STEPS + WIDE_CNT;
  localparam int STEP_W       = $clog2(TOTAL_STEPS);
  localparam int IDX_W        = 4;

  typedef enum logic [1:0] {
    GAP_SHORT = 2'd0,
    GAP_LONG  = 2'd1,
    GAP_STAB  = 2'd2
  } gap_e;

  typedef struct packed {
    logic             wide;
    logic [IDX_W-1:0] idx;
    gap_e             gap;
  } step_t;

  function automatic int unsigned ceil_div(int unsigned num, int unsigned den);
    return (num + den - 1) / den;
  endfunction

  // Step number to word index, width class and settling class.
  function automatic step_t decode_step(logic [STEP_W-1:0] step);
    step_t s;
    if (step < STEP_W'(NARROW_STEPS)) begin
      s.wide = 1'b0;
      s.idx  = (step <= STEP_W'(6)) ? step[IDX_W-1:0] : IDX_W'(step + STEP_W'(1));
      case (s.idx)
        4'd2, 4'd10:       s.gap = GAP_STAB;
        4'd3, 4'd4, 4'd5:  s.gap = GAP_LONG;
        default:           s.gap = GAP_SHORT;
      endcase
    end else begin
      s.wide = 1'b1;
      s.idx  = IDX_W'(step - STEP_W'(NARROW_STEPS - 1));
      case (s.idx)
        4'd3:    s.gap = GAP_STAB;
        4'd11:   s.gap = GAP_LONG;
        default: s.gap = GAP_SHORT;
      endcase
    end
    return s;
  endfunction
endpackage

// File: rtl/rcw_payload_mux.sv
module rcw_payload_mux #(
  parameter int NARROW_BITS = 4,
  parameter int WIDE_BITS   = 8
) (
  input  logic [rcw_pkg::NARROW_CNT*NARROW_BITS-1:0] narrow_cfg,
  input  logic [rcw_pkg::WIDE_CNT*WIDE_BITS-1:0]     wide_cfg,
  input  logic [rcw_pkg::IDX_W-1:0]                  idx,
  input  logic                                       wide,
  output logic [WIDE_BITS-1:0]                       data
);
  logic [NARROW_BITS-1:0] nw [rcw_pkg::NARROW_CNT];
  logic [WIDE_BITS-1:0]   ww [rcw_pkg::WIDE_CNT];

  for (genvar g = 0; g < rcw_pkg::NARROW_CNT; g++) begin : g_nw
    assign nw[g] = narrow_cfg[g*NARROW_BITS +: NARROW_BITS];
  end
  for (genvar g = 0; g < rcw_pkg::WIDE_CNT; g++) begin : g_ww
    assign ww[g] = wide_cfg[g*WIDE_BITS +: WIDE_BITS];
  end

  always_comb begin
    data = '0;
    if (wide) begin
      for (int k = 0; k < rcw_pkg::WIDE_CNT; k++)
        if (idx == rcw_pkg::IDX_W'(k + 1)) data = ww[k];
    end else if (idx == 4'd6) begin
      data = WIDE_BITS'({nw[7], nw[6]});
    end else begin
      for (int k = 0; k < rcw_pkg::NARROW_CNT; k++)
        if (idx == rcw_pkg::IDX_W'(k)) data = WIDE_BITS'(nw[k]);
    end
  end
endmodule

// File: rtl/rcw_gap_timer.sv
module rcw_gap_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;

  assign expire = run && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (load)               cnt <= load_val;
    else if (run && cnt != '0)   cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/rcw_loader.sv
module rcw_loader #(
  parameter int NARROW_BITS = 4,
  parameter int WIDE_BITS   = 8,
  parameter int CLK_PS      = 1250,
  parameter int STAB_US     = 5,
  parameter int SHORT_GAP   = 8,
  parameter int LONG_GAP    = 16
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       start_i,
  input  logic [rcw_pkg::NARROW_CNT*NARROW_BITS-1:0] narrow_cfg_i,
  input  logic [rcw_pkg::WIDE_CNT*WIDE_BITS-1:0]     wide_cfg_i,
  input  logic                                       cmd_ready_i,
  output logic                                       cmd_valid_o,
  output logic                                       cmd_wide_o,
  output logic [rcw_pkg::IDX_W-1:0]                  cmd_index_o,
  output logic [WIDE_BITS-1:0]                       cmd_data_o,
  output logic                                       busy_o,
  output logic                                       done_o
);
  import rcw_pkg::*;

  localparam int unsigned STAB_CYC = ceil_div(STAB_US * 1000000, CLK_PS);
  localparam int unsigned MAX_GAP  = (STAB_CYC > LONG_GAP) ? STAB_CYC : LONG_GAP;
  localparam int          CNT_W    = $clog2(MAX_GAP + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_GAP} state_e;

  state_e            state;
  logic [STEP_W-1:0] step;
  logic              done_q;
  step_t             cur;
  logic [CNT_W-1:0]  gap_len;

  // Named internal events
  logic hs_fire;
  logic gap_expire;
  logic last_step;

  assign cur       = decode_step(step);
  assign hs_fire   = (state == ST_ISSUE) && cmd_ready_i;
  assign last_step = (step == STEP_W'(TOTAL_STEPS - 1));

  always_comb begin
    case (cur.gap)
      GAP_LONG: gap_len = CNT_W'(LONG_GAP);
      GAP_STAB: gap_len = CNT_W'(STAB_CYC);
      default:  gap_len = CNT_W'(SHORT_GAP);
    endcase
  end

  rcw_gap_timer #(.CNT_W(CNT_W)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (hs_fire),
    .load_val (gap_len - 1'b1),
    .run      (state == ST_GAP),
    .expire   (gap_expire)
  );

  rcw_payload_mux #(.NARROW_BITS(NARROW_BITS), .WIDE_BITS(WIDE_BITS)) i_mux (
    .narrow_cfg (narrow_cfg_i),
    .wide_cfg   (wide_cfg_i),
    .idx        (cur.idx),
    .wide       (cur.wide),
    .data       (cmd_data_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      step   <= '0;
      done_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start_i) begin
          step   <= '0;
          done_q <= 1'b0;
          state  <= ST_ISSUE;
        end
        ST_ISSUE: if (hs_fire) state <= ST_GAP;
        ST_GAP: if (gap_expire) begin
          if (last_step) begin
            state  <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            step  <= step + 1'b1;
            state <= ST_ISSUE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_valid_o = (state == ST_ISSUE);
  assign cmd_wide_o  = cur.wide;
  assign cmd_index_o = cur.idx;
  assign busy_o      = (state != ST_IDLE);
  assign done_o      = done_q;
endmodule

// File: rtl/rcw_loader_chk.sv
module rcw_loader_chk #(
  parameter int WIDE_BITS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmd_valid,
  input logic                 cmd_ready,
  input logic                 cmd_wide,
  input logic [3:0]           cmd_index,
  input logic [WIDE_BITS-1:0] cmd_data,
  input logic                 busy,
  input logic                 done,
  input logic                 hs_fire,
  input logic                 gap_expire
);
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_index) && $stable(cmd_data) && $stable(cmd_wide));

  // R2
  no_lone_seven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_wide |-> cmd_index != 4'd7);

  // R3
  wide_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_wide |-> (cmd_index >= 4'd1) && (cmd_index <= 4'd11));

  // R4
  quiet_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_fire |=> !cmd_valid);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_valid && !busy);

  // R8
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(gap_expire));
endmodule

bind rcw_loader rcw_loader_chk #(.WIDE_BITS(WIDE_BITS)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid_o),
  .cmd_ready  (cmd_ready_i),
  .cmd_wide   (cmd_wide_o),
  .cmd_index  (cmd_index_o),
  .cmd_data   (cmd_data_o),
  .busy       (busy_o),
  .done       (done_o),
  .hs_fire    (hs_fire),
  .gap_expire (gap_expire)
);

// File: tb/test_rcw_loader.sv
module test_rcw_loader;
  localparam int CLK_PS  = 15000;
  localparam int STAB_US = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [63:0] narrow_cfg_i = '0;
  logic [87:0] wide_cfg_i = '0;
  logic        cmd_ready_i = 1'b1;
  logic        cmd_valid_o, cmd_wide_o, busy_o, done_o;
  logic [3:0]  cmd_index_o;
  logic [7:0]  cmd_data_o;

  int n_chk = 0;
  int n_bad = 0;
  int stab_exp;

  always #10ns clk = ~clk;

  rcw_loader #(.CLK_PS(CLK_PS), .STAB_US(STAB_US)) i_rcw_loader (.*);

  // {wide, index[3:0], gap class}: 0 short, 1 long, 2 stabilisation
  localparam logic [6:0] TBL [26] = '{
    7'h00, 7'h04, 7'h0A, 7'h0D, 7'h11, 7'h15, 7'h18, 7'h20, 7'h24, 7'h2A,
    7'h2C, 7'h30, 7'h34, 7'h38, 7'h3C,
    7'h44, 7'h48, 7'h4E, 7'h50, 7'h54, 7'h58, 7'h5C, 7'h60, 7'h64, 7'h68, 7'h6D
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  function automatic int nval(int k, int seed);
    return (k * 5 + seed) % 16;
  endfunction
  function automatic int wval(int k, int seed);
    return (k * 37 + seed * 3) % 256;
  endfunction

  task automatic load_cfg(input int seed);
    for (int k = 0; k < 16; k++) narrow_cfg_i[k*4 +: 4] = 4'(nval(k, seed));
    for (int k = 1; k <= 11; k++) wide_cfg_i[(k-1)*8 +: 8] = 8'(wval(k, seed));
  endtask

  task automatic run_seq(input int seed, input bit stalls);
    int g, exp_gap, exp_data, idx;
    bit wide;
    logic [7:0] hold_d;
    load_cfg(seed);
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    for (int i = 0; i < 26; i++) begin
      wide = TBL[i][6];
      idx  = int'(TBL[i][5:2]);
      case (TBL[i][1:0])
        2'd1:    exp_gap = 16;
        2'd2:    exp_gap = stab_exp;
        default: exp_gap = 8;
      endcase
      if (wide) exp_data = wval(idx, seed);
      else if (idx == 6) exp_data = nval(7, seed) * 16 + nval(6, seed);
      else exp_data = nval(idx, seed);
      chk(cmd_valid_o == 1'b1, "R7 valid offered", int'(cmd_valid_o), 1);
      chk(int'(cmd_index_o) == idx, wide ? "R3 wide index" : "R2 narrow index", int'(cmd_index_o), idx);
      chk(cmd_wide_o == wide, wide ? "R3 width flag" : "R2 width flag", int'(cmd_wide_o), int'(wide));
      chk(int'(cmd_data_o) == exp_data, wide ? "R3 data" : "R2 data", int'(cmd_data_o), exp_data);
      if (stalls && i == 2) chk(int'(cmd_index_o) == 2, "R8 start ignored while busy", int'(cmd_index_o), 2);
      if (stalls && (i == 0 || i == 17)) begin
        cmd_ready_i = 1'b0;
        hold_d = cmd_data_o;
        repeat (3) begin
          @(negedge clk);
          chk(cmd_valid_o && int'(cmd_index_o) == idx && cmd_data_o == hold_d,
              "R7 held under stall", int'(cmd_data_o), int'(hold_d));
        end
        cmd_ready_i = 1'b1;
      end
      @(negedge clk);
      g = 0;
      while (!cmd_valid_o && !done_o && g < 5000) begin
        g++;
        start_i = (stalls && i == 1 && g == 2);
        @(negedge clk);
      end
      start_i = 1'b0;
      case (TBL[i][1:0])
        2'd1:    chk(g == exp_gap, "R5 long gap", g, exp_gap);
        2'd2:    chk(g == exp_gap, "R6 stabilisation gap", g, exp_gap);
        default: chk(g == exp_gap, "R4 short gap", g, exp_gap);
      endcase
    end
    chk(done_o == 1'b1, "R8 done after last gap", int'(done_o), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    finish_run();
  end

  initial begin
    stab_exp = STAB_US * 1000000 / CLK_PS;
    if (stab_exp * CLK_PS < STAB_US * 1000000) stab_exp++;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(!cmd_valid_o && !done_o && !busy_o, "R1 in reset", int'({cmd_valid_o, done_o, busy_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cmd_valid_o && !done_o && !busy_o, "R1 after reset", int'({cmd_valid_o, done_o, busy_o}), 0);

    run_seq(3, 1'b1);
    repeat (5) begin
      @(negedge clk);
      chk(done_o && !cmd_valid_o, "R8 done holds", int'({done_o, cmd_valid_o}), 2);
    end

    run_seq(9, 1'b0);

    // R1 reset during a sequence
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    chk(done_o == 1'b0, "R8 done cleared by start", int'(done_o), 0);
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!cmd_valid_o && !done_o && !busy_o, "R1 mid-run reset", int'({cmd_valid_o, done_o, busy_o}), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(!cmd_valid_o && !busy_o, "R1 stays idle", int'({cmd_valid_o, busy_o}), 0);
    finish_run();
  end
endmodule